// File: doc/BRIEF.md
# Duplicate-Tag Coherence Controller for Four L1 Data Caches

This block keeps the private L1 data caches of four CPUs coherent using the four-state MESI scheme. It holds its own copy of every L1 tag together with that line's coherence state. Each CPU presents a miss or an upgrade as a held request. The controller grants one request at a time in round-robin order and looks the line up in the duplicate tags of the other three CPUs. It then settles the request in one of three ways: the line is copied from a peer L1, the peers that hold the line are invalidated, or the line is fetched through the shared L2 port.

Each L1 is modelled as direct-mapped with 16 lines. A line address is split into an index, which is the low `IDXW` bits, and a tag, which is the remaining upper bits. Snoop commands go only to CPUs whose duplicate tags show that they hold the line. Clean lines and dirty lines can both move from one L1 to another without passing through L2. The response to the requester gives the state in which it installs the line. In the same cycle as that response, the duplicate tags of the requester and of every snooped peer are rewritten.

Top module: `scu_dup_tags`

## Requirements
- R1: After reset, no response, snoop, transfer or L2 request is active, and every duplicate tag entry is invalid. A first access to any line therefore goes to L2.
- R2: Consider a read (`req_write`=0) whose line is held by no other CPU. It raises `l2_req` with the line address and keeps it raised until `l2_ack`. It then responds in the `l2_ack` cycle with state Exclusive. State codes are I=0, S=1, E=2, M=3.
- R3: A read whose line is held clean (S or E) by other CPUs is served from the lowest-numbered holder, shown one-hot on `xfer_src`. A share command (`snp_inval`=0) goes to every holder, the requester gets S, and L2 is not used.
- R4: A read whose line is held Modified by another CPU moves the line from that owner. The owner receives an invalidate command and the requester gets M, with no L2 access.
- R5: A write request (`req_write`=1) from a CPU that already holds the line invalidates every other holder. It raises no `xfer_src` and no L2 access, and the requester gets M.
- R6: A write request from a CPU that does not hold the line, where peers hold it, takes the data from one holder (a Modified one if present, else the lowest-numbered). It invalidates all holders and answers M.
- R7: A write request for a line that no CPU holds fetches through L2 and answers M. It sends no snoop.
- R8: Snoop commands go only to CPUs whose duplicate tag matches the line's index and tag in a valid state. A peer holding a different tag at the same index is not disturbed, and the requester never receives a snoop.
- R9: Simultaneous requests are granted round-robin, starting from the CPU after the one last granted.
- R10: Only one transaction is in progress at a time. At most one CPU sees a response in any cycle, and no response follows the previous one in the next cycle.
- R11: The duplicate tags are updated in the response cycle, so later lookups see the new states. After a migration the old owner no longer holds the line, and the new owner supplies it next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NCPU | Per-CPU request, held until that CPU's response |
| req_write | input | NCPU | Per-CPU request kind: 1 write/upgrade, 0 read |
| req_addr | input | NCPU*AW | Per-CPU line address, CPU i in bits [i*AW +: AW] |
| rsp_valid | output | NCPU | One-hot response to the granted CPU |
| rsp_state | output | 2 | State to install at the requester (I=0,S=1,E=2,M=3) |
| snp_valid | output | NCPU | CPUs receiving a snoop command this cycle |
| snp_inval | output | 1 | Snoop kind: 1 invalidate, 0 downgrade to shared |
| snp_addr | output | AW | Line address of the snoop |
| xfer_src | output | NCPU | One-hot CPU supplying the line cache-to-cache |
| l2_req | output | 1 | Fill request to the shared L2 |
| l2_addr | output | AW | Line address of the fill |
| l2_ack | input | 1 | Fill data returned from L2 |

## Verification
The tests take one line through a chain of states in which a fresh line comes from L2, clean copies are shared, an upgrade invalidates peers, a dirty line migrates, and the new owner then supplies the line. This chain separates the cache-to-cache, invalidation and L2 outcomes, and it also shows that the duplicate tags followed each earlier response. A second tag at the same index shows that lookups compare tags as well as indexes. A write miss to a clean exclusive peer and a write miss to an untouched line separate the write cases. Three simultaneous reads to one shared line show the round-robin grant order.

// File: rtl/scu_dup_tags.sv
module scu_dup_tags #(
  parameter int NCPU = 4,
  parameter int AW   = 12,
  parameter int IDXW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCPU-1:0]    req_valid,
  input  logic [NCPU-1:0]    req_write,
  input  logic [NCPU*AW-1:0] req_addr,
  output logic [NCPU-1:0]    rsp_valid,
  output logic [1:0]         rsp_state,
  output logic [NCPU-1:0]    snp_valid,
  output logic               snp_inval,
  output logic [AW-1:0]      snp_addr,
  output logic [NCPU-1:0]    xfer_src,
  output logic               l2_req,
  output logic [AW-1:0]      l2_addr,
  input  logic               l2_ack
);
  localparam int CW    = (NCPU > 1) ? $clog2(NCPU) : 1;
  localparam int LINES = 1 << IDXW;
  localparam int TW    = AW - IDXW;
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3;

  typedef enum logic [1:0] {PH_IDLE, PH_RESOLVE, PH_FILL} phase_t;

  logic [TW-1:0] dtag [NCPU][LINES];
  logic [1:0]    dst  [NCPU][LINES];

  phase_t        ph;
  logic [CW-1:0] rr, cur, win;
  logic          cur_w, found;
  logic [AW-1:0] cur_a;

  wire [IDXW-1:0] idx = cur_a[IDXW-1:0];
  wire [TW-1:0]   tg  = cur_a[AW-1:IDXW];

  always_comb begin
    found = 1'b0;
    win   = rr;
    for (int k = 0; k < NCPU; k++) begin
      int j;
      j = (int'(rr) + k) % NCPU;
      if (!found && req_valid[j]) begin
        found = 1'b1;
        win   = CW'(j);
      end
    end
  end

  logic [NCPU-1:0] hit, dirty, src_oh;
  logic            own_valid;

  always_comb begin
    for (int c = 0; c < NCPU; c++) begin
      hit[c]   = (CW'(c) != cur) && (dst[c][idx] != ST_I) && (dtag[c][idx] == tg);
      dirty[c] = hit[c] && (dst[c][idx] == ST_M);
    end
    own_valid = (dst[cur][idx] != ST_I) && (dtag[cur][idx] == tg);
    src_oh = '0;
    for (int c = NCPU - 1; c >= 0; c--) begin
      if ((|dirty) ? dirty[c] : hit[c]) src_oh = NCPU'(1) << c;
    end
  end

  wire upgrade   = cur_w && own_valid;
  wire need_l2   = ~|hit && !upgrade;
  wire peer_data = (|hit) && !upgrade;
  wire inval     = cur_w || (|dirty);
  wire [1:0] new_st = (cur_w || (|dirty)) ? ST_M : ((|hit) ? ST_S : ST_E);
  wire resolve_now  = (ph == PH_RESOLVE) && !need_l2;
  wire fire         = resolve_now || ((ph == PH_FILL) && l2_ack);

  assign rsp_valid = fire ? (NCPU'(1) << cur) : '0;
  assign rsp_state = new_st;
  assign snp_valid = resolve_now ? hit : '0;
  assign snp_inval = inval;
  assign snp_addr  = cur_a;
  assign xfer_src  = (resolve_now && peer_data) ? src_oh : '0;
  assign l2_req    = (ph == PH_FILL);
  assign l2_addr   = cur_a;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= PH_IDLE;
      rr    <= '0;
      cur   <= '0;
      cur_w <= 1'b0;
      cur_a <= '0;
      for (int c = 0; c < NCPU; c++)
        for (int l = 0; l < LINES; l++) begin
          dst[c][l]  <= ST_I;
          dtag[c][l] <= '0;
        end
    end else begin
      case (ph)
        PH_IDLE: if (found) begin
          cur   <= win;
          cur_w <= req_write[win];
          cur_a <= req_addr[int'(win)*AW +: AW];
          rr    <= CW'((int'(win) + 1) % NCPU);
          ph    <= PH_RESOLVE;
        end
        PH_RESOLVE: ph <= need_l2 ? PH_FILL : PH_IDLE;
        PH_FILL:    if (l2_ack) ph <= PH_IDLE;
        default:    ph <= PH_IDLE;
      endcase
      if (fire) begin
        for (int c = 0; c < NCPU; c++)
          if (hit[c]) dst[c][idx] <= inval ? ST_I : ST_S;
        dst[cur][idx]  <= new_st;
        dtag[cur][idx] <= tg;
      end
    end
  end
endmodule

// File: rtl/scu_dup_tags_chk.sv
module scu_dup_tags_chk #(
  parameter int NCPU = 4,
  parameter int AW   = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NCPU-1:0] rsp_valid,
  input logic [1:0]      rsp_state,
  input logic [NCPU-1:0] snp_valid,
  input logic            snp_inval,
  input logic [NCPU-1:0] xfer_src,
  input logic            l2_req,
  input logic [AW-1:0]   l2_addr,
  input logic            l2_ack
);
  assert_one_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_valid));
  assert_rsp_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|rsp_valid) |=> !(|rsp_valid));
  assert_l2_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (l2_req && !l2_ack) |=> (l2_req && $stable(l2_addr)));
  assert_no_self_snoop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid & rsp_valid) == '0);
  assert_src_is_holder_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(xfer_src) && ((xfer_src & ~snp_valid) == '0));
  assert_fill_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    l2_req |-> (snp_valid == '0 && xfer_src == '0));
  assert_excl_alone_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((|rsp_valid) && rsp_state == 2'd2) |-> (snp_valid == '0 && xfer_src == '0));
  assert_share_gives_s_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((|snp_valid) && !snp_inval) |-> (rsp_state == 2'd1 && (|xfer_src)));
endmodule

bind scu_dup_tags scu_dup_tags_chk #(.NCPU(NCPU), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_state(rsp_state),
  .snp_valid(snp_valid), .snp_inval(snp_inval), .xfer_src(xfer_src),
  .l2_req(l2_req), .l2_addr(l2_addr), .l2_ack(l2_ack)
);

// File: tb/tb_scu_dup_tags.sv
`timescale 1ns/1ps
module tb_scu_dup_tags;
  localparam int NCPU = 4, AW = 12;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCPU-1:0] req_valid = '0, req_write = '0;
  logic [NCPU*AW-1:0] req_addr = '0;
  logic [NCPU-1:0] rsp_valid, snp_valid, xfer_src;
  logic [1:0] rsp_state;
  logic snp_inval, l2_req, l2_ack = 1'b0;
  logic [AW-1:0] snp_addr, l2_addr;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  scu_dup_tags dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic txn(input int c, input bit w, input logic [AW-1:0] a, input bit exp_l2,
                     input logic [1:0] exp_st, input logic [3:0] exp_snp, input bit exp_inv,
                     input logic [3:0] exp_xfer, input string req);
    bit saw_l2 = 0, done = 0;
    int l2_wait = 0, n = 0;
    logic [1:0] st = 0; logic [3:0] snp = 0, xf = 0; logic inv = 0;
    req_write[c] = w;
    req_addr[c*AW +: AW] = a;
    req_valid[c] = 1'b1;
    while (!done && n < 50) begin
      @(negedge clk); n++;
      if (l2_req) begin
        if (!saw_l2) chk(l2_addr == a, {req, " l2_addr"}, 32'(l2_addr), 32'(a));
        saw_l2 = 1;
        l2_wait++;
        if (l2_wait == 2) begin l2_ack = 1'b1; #1; end
      end
      if (rsp_valid != 0) begin
        chk(rsp_valid == 4'(1 << c), {req, " rsp target"}, 32'(rsp_valid), 32'(1 << c));
        st = rsp_state; snp = snp_valid; inv = snp_inval; xf = xfer_src;
        if (snp != 0) chk(snp_addr == a, {req, " snp_addr"}, 32'(snp_addr), 32'(a));
        done = 1;
      end
    end
    chk(done, {req, " response seen"}, 32'(done), 1);
    chk(saw_l2 == exp_l2, {req, " L2 use"}, 32'(saw_l2), 32'(exp_l2));
    chk(st == exp_st, {req, " state"}, 32'(st), 32'(exp_st));
    chk(snp == exp_snp, {req, " snoop targets"}, 32'(snp), 32'(exp_snp));
    if (exp_snp != 0) chk(inv == exp_inv, {req, " snoop kind"}, 32'(inv), 32'(exp_inv));
    chk(xf == exp_xfer, {req, " transfer source"}, 32'(xf), 32'(exp_xfer));
    @(posedge clk); #1;
    l2_ack = 1'b0;
    req_valid[c] = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 0, {req, " R10 no back-to-back rsp"}, 32'(rsp_valid), 0);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(rsp_valid == 0 && snp_valid == 0 && xfer_src == 0 && !l2_req, "R1 idle outputs",
        {rsp_valid, snp_valid, xfer_src, 3'b0, l2_req}, 0);
  endtask

  task automatic test_chain();
    txn(0, 0, 12'h105, 1, 2'd2, 4'b0000, 0, 4'b0000, "R2 read miss to L2");
    txn(1, 0, 12'h105, 0, 2'd1, 4'b0001, 0, 4'b0001, "R3 read from E peer");
    txn(2, 0, 12'h105, 0, 2'd1, 4'b0011, 0, 4'b0001, "R3 read from two S peers");
    txn(1, 1, 12'h105, 0, 2'd3, 4'b0101, 1, 4'b0000, "R5 upgrade from S");
    txn(3, 0, 12'h105, 0, 2'd3, 4'b0010, 1, 4'b0010, "R4 dirty migration");
    txn(0, 0, 12'h105, 0, 2'd3, 4'b1000, 1, 4'b1000, "R11 new owner supplies");
  endtask

  task automatic test_alias_and_writes();
    txn(2, 0, 12'h205, 1, 2'd2, 4'b0000, 0, 4'b0000, "R8 same index other tag");
    txn(1, 1, 12'h205, 0, 2'd3, 4'b0100, 1, 4'b0100, "R6 write miss from E peer");
    txn(3, 1, 12'h3AA, 1, 2'd3, 4'b0000, 0, 4'b0000, "R7 write miss to L2");
  endtask

  task automatic test_round_robin();
    int order[3]; int got = 0, n = 0; bit saw_l2 = 0;
    txn(1, 0, 12'h0C1, 1, 2'd2, 4'b0000, 0, 4'b0000, "R9 setup fill");
    foreach (order[i]) order[i] = -1;
    for (int c = 0; c < NCPU; c++) if (c != 1) begin
      req_write[c] = 1'b0; req_addr[c*AW +: AW] = 12'h0C1; req_valid[c] = 1'b1;
    end
    while (got < 3 && n < 100) begin
      @(negedge clk); n++;
      if (l2_req) saw_l2 = 1;
      chk($onehot0(rsp_valid), "R10 single response", 32'(rsp_valid), 0);
      for (int c = 0; c < NCPU; c++) if (rsp_valid[c]) begin
        chk(rsp_state == 2'd1, "R3 shared on concurrent read", 32'(rsp_state), 1);
        if (got < 3) order[got] = c;
        got++;
        @(posedge clk); #1; req_valid[c] = 1'b0;
      end
    end
    chk(!saw_l2, "R9 no L2 for held line", 32'(saw_l2), 0);
    chk(order[0] == 2, "R9 first grant", 32'(order[0]), 2);
    chk(order[1] == 3, "R9 second grant", 32'(order[1]), 3);
    chk(order[2] == 0, "R9 third grant", 32'(order[2]), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    test_reset();
    test_chain();
    test_alias_and_writes();
    test_round_robin();
    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule